// File: doc/BRIEF.md
# Pin Bank with Interrupt Sensing

A word-addressed bank of up to 32 general-purpose pins. Each pin is configured as a plain input, a driven output, or an interrupt source. Every register holds one bit per pin, and software reads and writes each register as a whole word. The pad inputs are brought into the clock domain through two flops. The synchronised value feeds the input-data register and the interrupt sensing logic.

A pin takes part in interrupt sensing only while its mode bit selects interrupt. In that mode it watches for a high level, a low level, a rising edge, a falling edge or both edges. Edge events are latched until software clears them. Level events follow the pin. The latched or live status is ANDed with a per-pin enable and ORed into one registered interrupt line.

The enable register has two write ports. Writing the enable register directly can only turn bits off: a 0 disables that pin and a 1 leaves the bit unchanged. A separate unmask register turns bits on: a 1 enables that pin.

Top module: `pinbank_irq`

## Requirements
- R1: After synchronous reset every readable register returns 0, `pad_oe` is 0 and `irq_out` is 0.
- R2: `pad_out` equals the output-data register (offset 0x08). `pad_oe` bit i is high exactly when direction bit i (offset 0x04) is 1 and mode bit i (offset 0x00) is 0.
- R3: Offset 0x0C returns `pad_in` delayed by the two-flop synchroniser, whatever the direction bits say. Writes to 0x0C change nothing.
- R4: A pin with mode bit 1 and edge/level bit 0 (offset 0x24) sets its status bit (offset 0x10) while the synchronised pad equals NOT polarity (offset 0x20). Polarity 0 means active high and 1 means active low. When the level goes inactive, the status bit drops without any clear.
- R5: A pin with mode bit 1, edge/level bit 1, polarity 0 and both-edge bit 0 (offset 0x4C) latches its status on a rising edge and holds it after the pad returns low.
- R6: With polarity 1 in edge mode, only a falling edge sets the status; a rising edge does not.
- R7: With both-edge bit 1 in edge mode, a rising edge and a falling edge each set the status, regardless of polarity.
- R8: Writing 1 to a bit of offset 0x14 clears that pin's latched edge status, and writing 0 has no effect. If a new edge and a clear arrive in the same cycle, the status ends up set.
- R9: A pin whose mode bit is 0 never shows status, whatever edges its pad makes.
- R10: Writing offset 0x18 clears each enable bit written as 0 and keeps each bit written as 1. Writing 1 to offset 0x1C sets that enable bit. Offset 0x18 reads the enables, and offset 0x1C reads 0.
- R11: `irq_out` is high, one clock after the status update, exactly when some bit is set in both status and enable.
- R12: Offset 0x28 is a plain read/write register with no effect on sensing. Offsets outside the map, and offsets that are not word aligned, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, registered one cycle |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Output levels to the pads |
| pad_oe | output | NPINS | Output enables to the pads |
| irq_out | output | 1 | Combined, enabled interrupt request |

## Verification
Level sensing is exercised with all four combinations of polarity and pad level on one pin. The pad is dropped without a clear to show that level status is not latched. Edge sensing is driven in three modes:
- polarity 0, which separates rising from falling edges;
- polarity 1, which separates falling from rising edges;
- both-edge, which must react to either edge.

A clear is timed to land in the same cycle as a fresh edge to show that the set wins. The same pad toggles are repeated with the mode bit at 0 to show that a pin in general mode cannot raise status. Status is then held while the enable bits are toggled, which separates a raw status bit from the interrupt line.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  // Byte offsets of the register map
  localparam int unsigned OFS_MODE  = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_OUT   = 'h08;
  localparam int unsigned OFS_IN    = 'h0C;
  localparam int unsigned OFS_STAT  = 'h10;
  localparam int unsigned OFS_CLR   = 'h14;
  localparam int unsigned OFS_MASK  = 'h18;
  localparam int unsigned OFS_UNMSK = 'h1C;
  localparam int unsigned OFS_POL   = 'h20;
  localparam int unsigned OFS_EDGE  = 'h24;
  localparam int unsigned OFS_FILT  = 'h28;
  localparam int unsigned OFS_BOTH  = 'h4C;
  localparam int unsigned BUS_W     = 32;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pinbank_sense.sv
module pinbank_sense #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] edg,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit, lvl;
    always_comb begin
      rise = smp[i] & ~prev_q[i];
      fall = ~smp[i] & prev_q[i];
      hit  = both[i] ? (rise | fall) : (pol[i] ? fall : rise);
      lvl  = smp[i] ^ pol[i];
    end
    always_ff @(posedge clk) begin
      if (rst || !mode[i]) stat[i] <= 1'b0;
      else if (!edg[i])    stat[i] <= lvl;
      else                 stat[i] <= hit | (stat[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_out
);
  localparam int N = NPINS;

  logic [N-1:0] mode_q, dir_q, out_q, pol_q, edg_q, both_q, filt_q, mask_q;
  logic [N-1:0] smp, stat_q, clr_vec, wd;
  logic         aligned;

  assign wd      = bus_wdata[N-1:0];
  assign aligned = (bus_addr[1:0] == 2'b00);

  function automatic logic hit_ofs(input logic [ADDR_W-1:0] a, input int unsigned o);
    return a == ADDR_W'(o);
  endfunction

  pinbank_sync #(.W(N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (smp)
  );

  assign clr_vec = (bus_wr && hit_ofs(bus_addr, OFS_CLR)) ? wd : '0;

  pinbank_sense #(.W(N)) u_sense (
    .clk  (clk),
    .rst  (rst),
    .smp  (smp),
    .mode (mode_q),
    .edg  (edg_q),
    .pol  (pol_q),
    .both (both_q),
    .clr  (clr_vec),
    .stat (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '0;
      edg_q  <= '0;
      both_q <= '0;
      filt_q <= '0;
      mask_q <= '0;
    end else if (bus_wr && aligned) begin
      if (hit_ofs(bus_addr, OFS_MODE))  mode_q <= wd;
      if (hit_ofs(bus_addr, OFS_DIR))   dir_q  <= wd;
      if (hit_ofs(bus_addr, OFS_OUT))   out_q  <= wd;
      if (hit_ofs(bus_addr, OFS_POL))   pol_q  <= wd;
      if (hit_ofs(bus_addr, OFS_EDGE))  edg_q  <= wd;
      if (hit_ofs(bus_addr, OFS_BOTH))  both_q <= wd;
      if (hit_ofs(bus_addr, OFS_FILT))  filt_q <= wd;
      if (hit_ofs(bus_addr, OFS_MASK))  mask_q <= mask_q & wd;
      if (hit_ofs(bus_addr, OFS_UNMSK)) mask_q <= mask_q | wd;
    end
  end

  logic [N-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    if (hit_ofs(bus_addr, OFS_MODE))  rd_sel = mode_q;
    if (hit_ofs(bus_addr, OFS_DIR))   rd_sel = dir_q;
    if (hit_ofs(bus_addr, OFS_OUT))   rd_sel = out_q;
    if (hit_ofs(bus_addr, OFS_IN))    rd_sel = smp;
    if (hit_ofs(bus_addr, OFS_STAT))  rd_sel = stat_q;
    if (hit_ofs(bus_addr, OFS_MASK))  rd_sel = mask_q;
    if (hit_ofs(bus_addr, OFS_POL))   rd_sel = pol_q;
    if (hit_ofs(bus_addr, OFS_EDGE))  rd_sel = edg_q;
    if (hit_ofs(bus_addr, OFS_FILT))  rd_sel = filt_q;
    if (hit_ofs(bus_addr, OFS_BOTH))  rd_sel = both_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= 32'(rd_sel);
      irq_out   <= |(stat_q & mask_q);
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q & ~mode_q;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              irq_out,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  edg_q,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  mask_q
);
  logic [NPINS-1:0] clr_seen, keep;
  assign clr_seen = (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata[NPINS-1:0] : '0;
  assign keep     = stat_q & mode_q & edg_q & ~clr_seen;

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(keep)) == $past(keep)));

  // R9
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(mode_q)) == '0));

  // R10
  mask_off_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> ((mask_q & ~$past(bus_wdata[NPINS-1:0])) == '0));
endmodule

bind pinbank_irq pinbank_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .mode_q    (mode_q),
  .edg_q     (edg_q),
  .stat_q    (stat_q),
  .mask_q    (mask_q)
);

// File: tb/pinbank_irq_test.sv
module pinbank_irq_test;
  localparam int NPINS  = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pad_in = '0;
  logic [NPINS-1:0]  pad_out, pad_oe;
  logic              irq_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pinbank_irq #(.NPINS(NPINS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // {polarity, pad level, expected status} for pin 3 in level mode
  localparam logic [2:0] LVL_TAB [4] = '{3'b011, 3'b000, 3'b101, 3'b110};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 mode", v, 0);
    rd(8'h18, v); chk("R1 mask", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);

    // R2 direction and output data
    wr(8'h04, 32'h0000_00F0);
    wr(8'h08, 32'h0000_00A0);
    @(negedge clk);
    chk("R2 pad_oe", pad_oe, 32'h0000_00F0);
    chk("R2 pad_out", pad_out, 32'h0000_00A0);
    wr(8'h00, 32'h0000_0010);
    @(negedge clk);
    chk("R2 oe off in irq mode", pad_oe, 32'h0000_00E0);
    wr(8'h00, 32'h0);

    // R3 input data
    pad_in = 32'h1234_5678;
    settle();
    rd(8'h0C, v); chk("R3 input", v, 32'h1234_5678);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R3 read-only", v, 32'h1234_5678);
    pad_in = '0;

    // R4 level sensing, table driven
    wr(8'h24, 32'h0);
    wr(8'h00, 32'h0000_0008);
    for (int i = 0; i < 4; i++) begin
      wr(8'h20, {28'b0, LVL_TAB[i][2], 3'b0});
      pad_in[3] = LVL_TAB[i][1];
      settle();
      rd(8'h10, v);
      chk($sformatf("R4 level entry %0d", i), v, {28'b0, LVL_TAB[i][0], 3'b0});
    end
    pad_in = '0;

    // R5 rising edge, sticky
    wr(8'h00, 32'h20); wr(8'h24, 32'h20); wr(8'h20, 32'h0); wr(8'h4C, 32'h0);
    settle();
    pad_in[5] = 1'b1; settle();
    rd(8'h10, v); chk("R5 rise sets", v, 32'h20);
    pad_in[5] = 1'b0; settle();
    rd(8'h10, v); chk("R5 sticky", v, 32'h20);
    // R8 clear semantics
    wr(8'h14, 32'h0);
    rd(8'h10, v); chk("R8 zero no effect", v, 32'h20);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R8 one clears", v, 0);

    // R6 falling edge only
    wr(8'h20, 32'h20);
    pad_in[5] = 1'b1; settle();
    rd(8'h10, v); chk("R6 rise ignored", v, 0);
    pad_in[5] = 1'b0; settle();
    rd(8'h10, v); chk("R6 fall sets", v, 32'h20);
    wr(8'h14, 32'h20);

    // R7 both edges
    wr(8'h20, 32'h0); wr(8'h4C, 32'h20);
    pad_in[5] = 1'b1; settle();
    rd(8'h10, v); chk("R7 rise", v, 32'h20);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R7 cleared", v, 0);
    pad_in[5] = 1'b0; settle();
    rd(8'h10, v); chk("R7 fall", v, 32'h20);
    wr(8'h14, 32'h20);

    // R8 edge wins over same-cycle clear
    @(negedge clk); pad_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h14; bus_wdata = 32'h20; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    settle();
    rd(8'h10, v); chk("R8 set priority", v, 32'h20);
    wr(8'h14, 32'h20);

    // R9 mode bit 0 blocks sensing
    wr(8'h00, 32'h0);
    pad_in[5] = 1'b0; settle();
    pad_in[5] = 1'b1; settle();
    rd(8'h10, v); chk("R9 no status", v, 0);

    // R10 / R11 enables and interrupt line
    wr(8'h00, 32'h20);
    pad_in[5] = 1'b0; settle();
    chk("R11 masked", {31'b0, irq_out}, 0);
    wr(8'h1C, 32'h21);
    rd(8'h18, v); chk("R10 unmask", v, 32'h21);
    rd(8'h1C, v); chk("R10 unmask reads zero", v, 0);
    settle();
    chk("R11 irq up", {31'b0, irq_out}, 1);
    wr(8'h18, 32'hFFFF_FFDF);
    rd(8'h18, v); chk("R10 zero disables", v, 32'h01);
    settle();
    chk("R11 irq down", {31'b0, irq_out}, 0);

    // R12 filter register and unmapped offsets
    wr(8'h28, 32'h0000_ABCD);
    rd(8'h28, v); chk("R12 filter rw", v, 32'h0000_ABCD);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); chk("R12 unmapped read", v, 0);
    wr(8'h19, 32'h0);
    rd(8'h18, v); chk("R12 unaligned write ignored", v, 32'h01);
    rd(8'h05, v); chk("R12 unaligned read", v, 0);
    rd(8'h04, v); chk("R12 dir intact", v, 32'h0000_00F0);

    finish_run();
  end
endmodule